// File: doc/BRIEF.md
# Serial Programming Command Slave

This block sits beside the nonvolatile arrays of a small transmitter controller and lets an external programmer load and verify them over a three-wire serial link. The link is live only while the device reset pin is held low. Every command is exactly 32 bits long, sent most significant bit first. The block takes SCK, SDI and the reset pin into the crystal-clock domain. It then decodes each command and drives one-cycle read, write or erase strobes, with an address, a byte select and write data, toward the memory models.

Nothing is accepted until an arming command arrives. After that the programmer can read or write the program memory (1K words of 16 bits, addressed one byte at a time), the 128-byte data memory and the 64 I/O registers. It can also erase everything and set two sticky protection bits. An accepted write opens a busy window, and any further write that arrives inside that window is dropped. Read data comes back on SDO during the fourth byte of the read command.

Top module: `isp_cmd_slave`

## Requirements
- R1: A command is 32 bits. SDI is sampled on each rising SCK edge, MSB first. Byte 1 is the opcode, bytes 2 and 3 carry the address, and byte 4 carries the write data. Writes take effect once the 32nd rising edge has been seen.
- R2: SDO changes only after falling SCK edges and is shifted MSB first. The 8 bits of read data appear on SDO ahead of the 8 rising edges of byte 4.
- R3: After the reset pin goes low, every command is ignored until bytes 1 and 2 equal 0xAC, 0x53. Raising the pin clears this armed state and any partly received command.
- R4: Program memory: opcode 0x20 reads and 0x40 writes. Opcode bit 3 set (0x28, 0x48) selects the high byte of the word. The 10-bit word address is byte 2 bits 1:0 followed by byte 3.
- R5: Data memory uses 0xA0 (read) and 0xC0 (write) with the address in byte 3 bits 6:0. I/O uses 0xB0 (read) and 0xD0 (write) with the address in byte 3 bits 5:0.
- R6: Byte 1 0xAC with byte 2 bits 7:5 = 100 issues one erase strobe, which sets all program and data locations to 0xFF. It also returns both lock bits to unprogrammed (lock_n = 2'b11).
- R7: Byte 1 0xAC with byte 2 bits 7:5 = 111 writes the lock bits. A 0 in byte 2 bit 1 clears lock_n[0], and a 0 in bit 2 clears lock_n[1]. A 1 never sets a lock bit again; only erase does.
- R8: While lock_n[0] is 0, program and data memory writes produce no strobe. I/O writes still happen.
- R9: While lock_n is 2'b00, program and data memory reads produce no strobe and return 0x00. I/O reads still work.
- R10: An accepted write, erase or lock write raises busy for BUSY_CLKS clocks. Any write, erase or lock command that completes while busy is high is dropped.
- R11: After system reset, all strobes are low, busy is low, SDO is low and lock_n is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_rst_n | input | 1 | Device reset pin; low enables the serial link |
| sck | input | 1 | Serial clock from programmer |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_erase | output | 1 | One-cycle erase-all strobe |
| mem_sel | output | 2 | Target: 0 program, 1 data, 2 I/O |
| mem_addr | output | PM_AW | Word or byte address |
| mem_hi | output | 1 | High byte of program word |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from selected target, valid in the strobe cycle |
| busy | output | 1 | Write busy window active |
| lock_n | output | 2 | Lock bits, 1 = unprogrammed |

## Verification
The bench writes before arming and after the pin has been toggled. A slave that ignored the arming rule would write a location that a later read shows unchanged. It sends a second write straight after the first. A slave without the busy rule would overwrite the first value. The lock steps set lock 1 only and then both locks. A slave that mixed up the two lock bits or their scopes would either change program memory, block I/O access, or return real data instead of zero. The bench also reads back high and low bytes, data-memory addresses with byte 3 bit 7 set, and the values after an erase. Those reads catch a swapped byte select, an address that is too wide, and an erase that leaves the lock bits programmed.

// File: rtl/isp_pkg.sv
// Shared encodings for the serial programming slave.
// Assumes 8-bit opcode bytes and a four-byte command frame.
package isp_pkg;
    typedef enum logic [1:0] {
        TGT_PMEM = 2'd0,
        TGT_DMEM = 2'd1,
        TGT_IO   = 2'd2
    } tgt_e;

    localparam logic [7:0] OP_GUARD  = 8'hAC;
    localparam logic [7:0] OP_ARM2   = 8'h53;
    localparam logic [7:0] OP_PM_RD  = 8'h20;
    localparam logic [7:0] OP_PM_WR  = 8'h40;
    localparam logic [7:0] OP_HI_MSK = 8'hF7;
    localparam logic [7:0] OP_DM_RD  = 8'hA0;
    localparam logic [7:0] OP_DM_WR  = 8'hC0;
    localparam logic [7:0] OP_IO_RD  = 8'hB0;
    localparam logic [7:0] OP_IO_WR  = 8'hD0;
    localparam logic [2:0] SUB_ERASE = 3'b100;
    localparam logic [2:0] SUB_LOCK  = 3'b111;
endpackage

// File: rtl/isp_pin_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes the pin is held stable for longer than STAGES clocks.
module isp_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
// Frame shifter: collects SDI bits on rising SCK, flags the 24th and the
// last bit, and shifts a loaded byte out on falling SCK.
// Assumes rise/fall are single-cycle pulses from a synchronized SCK.
module isp_shifter #(
    parameter int FRAME_BITS = 32,
    parameter int HDR_BITS   = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  sdi_s,
    input  logic                  load,
    input  logic [7:0]            load_data,
    output logic                  hdr_valid,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  sdo
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [CW-1:0] cnt;
    logic [7:0]    tx;

    // Count bits, shift input, shift output; cleared while the link is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt         <= '0;
            frame       <= '0;
            hdr_valid   <= 1'b0;
            frame_valid <= 1'b0;
            tx          <= '0;
            sdo         <= 1'b0;
        end else begin
            hdr_valid   <= 1'b0;
            frame_valid <= 1'b0;
            if (rise) begin
                frame       <= {frame[FRAME_BITS-2:0], sdi_s};
                cnt         <= (cnt == CW'(FRAME_BITS-1)) ? '0 : cnt + 1'b1;
                hdr_valid   <= (cnt == CW'(HDR_BITS-1));
                frame_valid <= (cnt == CW'(FRAME_BITS-1));
            end
            if (load) begin
                tx <= load_data;
            end else if (fall) begin
                sdo <= tx[7];
                tx  <= {tx[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_busy_timer.sv
// Busy window: held for CLKS cycles after a start pulse.
// Assumes CLKS >= 1.
module isp_busy_timer #(
    parameter int CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CLKS + 1);

    logic [CW-1:0] left;

    // Reload on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         left <= '0;
        else if (start)     left <= CW'(CLKS);
        else if (left != 0) left <= left - 1'b1;
    end

    assign busy = (left != 0);
endmodule

// File: rtl/isp_decode.sv
// Command decoder: arming, read/write/erase strobes, lock bits.
// Assumes mem_rdata is valid combinationally in the cycle of mem_rd.
module isp_decode
    import isp_pkg::*;
#(
    parameter int PM_AW = 10,
    parameter int DM_AW = 7,
    parameter int IO_AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             hdr_valid,
    input  logic             frame_valid,
    input  logic [31:0]      frame,
    input  logic             busy,
    input  logic [7:0]       mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_erase,
    output logic [1:0]       mem_sel,
    output logic [PM_AW-1:0] mem_addr,
    output logic             mem_hi,
    output logic [7:0]       mem_wdata,
    output logic [1:0]       lock_n,
    output logic             busy_start,
    output logic             load,
    output logic [7:0]       load_data
);
    localparam int PMH = PM_AW - 8;

    logic [7:0] w1, w2, w3, w4, h1, h2, h3;
    logic       armed, wr_ok, verify_ok;

    assign {w1, w2, w3, w4} = frame;
    assign {h1, h2, h3}     = frame[23:0];
    assign wr_ok            = lock_n[0];
    assign verify_ok        = (lock_n != 2'b00);

    // Track arming, issue strobes and keep the lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0; mem_rd <= 1'b0; mem_wr <= 1'b0; mem_erase <= 1'b0;
            mem_sel <= TGT_PMEM; mem_addr <= '0; mem_hi <= 1'b0; mem_wdata <= '0;
            lock_n <= 2'b11; busy_start <= 1'b0; load <= 1'b0; load_data <= '0;
        end else begin
            mem_rd <= 1'b0; mem_wr <= 1'b0; mem_erase <= 1'b0;
            busy_start <= 1'b0; load <= 1'b0;
            if (!active) armed <= 1'b0;
            else if (frame_valid && w1 == OP_GUARD && w2 == OP_ARM2) armed <= 1'b1;

            if (mem_rd) begin
                load      <= 1'b1;
                load_data <= mem_rdata;
            end

            if (active && armed && hdr_valid) begin
                if ((h1 & OP_HI_MSK) == OP_PM_RD || h1 == OP_DM_RD) begin
                    if (verify_ok) begin
                        mem_rd   <= 1'b1;
                        mem_sel  <= (h1 == OP_DM_RD) ? TGT_DMEM : TGT_PMEM;
                        mem_addr <= (h1 == OP_DM_RD) ? PM_AW'(h3[DM_AW-1:0])
                                                     : PM_AW'({h2[PMH-1:0], h3});
                        mem_hi   <= (h1 != OP_DM_RD) && h1[3];
                    end else begin
                        load      <= 1'b1;
                        load_data <= '0;
                    end
                end else if (h1 == OP_IO_RD) begin
                    mem_rd   <= 1'b1;
                    mem_sel  <= TGT_IO;
                    mem_addr <= PM_AW'(h3[IO_AW-1:0]);
                    mem_hi   <= 1'b0;
                end
            end

            if (active && armed && frame_valid && !busy) begin
                if ((w1 & OP_HI_MSK) == OP_PM_WR && wr_ok) begin
                    mem_wr <= 1'b1; busy_start <= 1'b1;
                    mem_sel <= TGT_PMEM; mem_addr <= PM_AW'({w2[PMH-1:0], w3});
                    mem_hi <= w1[3]; mem_wdata <= w4;
                end else if (w1 == OP_DM_WR && wr_ok) begin
                    mem_wr <= 1'b1; busy_start <= 1'b1;
                    mem_sel <= TGT_DMEM; mem_addr <= PM_AW'(w3[DM_AW-1:0]);
                    mem_hi <= 1'b0; mem_wdata <= w4;
                end else if (w1 == OP_IO_WR) begin
                    mem_wr <= 1'b1; busy_start <= 1'b1;
                    mem_sel <= TGT_IO; mem_addr <= PM_AW'(w3[IO_AW-1:0]);
                    mem_hi <= 1'b0; mem_wdata <= w4;
                end else if (w1 == OP_GUARD && w2[7:5] == SUB_ERASE) begin
                    mem_erase <= 1'b1; busy_start <= 1'b1;
                    lock_n <= 2'b11;
                end else if (w1 == OP_GUARD && w2[7:5] == SUB_LOCK) begin
                    busy_start <= 1'b1;
                    lock_n <= lock_n & {w2[2], w2[1]};
                end
            end
        end
    end
endmodule

// File: rtl/isp_cmd_slave.sv
// Top of the serial programming slave: pin synchronizers, SCK edge
// detection, frame shifter, command decoder and busy timer.
// Assumes SCK low/high phases of at least 4/16 clk cycles.
module isp_cmd_slave
    import isp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CLKS   = 64,
    parameter int PM_AW       = 10,
    parameter int DM_AW       = 7,
    parameter int IO_AW       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_rst_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             sdo,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_erase,
    output logic [1:0]       mem_sel,
    output logic [PM_AW-1:0] mem_addr,
    output logic             mem_hi,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic [1:0]       lock_n
);
    localparam int         NPIN     = 3;
    localparam logic [2:0] PIN_RST  = 3'b100;
    localparam int         FRAME_W  = 32;

    logic [NPIN-1:0] pin_raw, pin_s;
    logic            sck_d, rise, fall, active;
    logic            hdr_valid, frame_valid, busy_start, load;
    logic [FRAME_W-1:0] frame;
    logic [7:0]      load_data;

    assign pin_raw = {prog_rst_n, sck, sdi};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        isp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g])
        );
    end

    // Delay the synchronized SCK one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pin_s[1];
    end

    assign rise   = pin_s[1] & ~sck_d;
    assign fall   = ~pin_s[1] & sck_d;
    assign active = ~pin_s[2];

    isp_shifter #(.FRAME_BITS(FRAME_W), .HDR_BITS(24)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .rise(rise), .fall(fall),
        .sdi_s(pin_s[0]), .load(load), .load_data(load_data),
        .hdr_valid(hdr_valid), .frame_valid(frame_valid), .frame(frame), .sdo(sdo)
    );

    isp_decode #(.PM_AW(PM_AW), .DM_AW(DM_AW), .IO_AW(IO_AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .active(active), .hdr_valid(hdr_valid),
        .frame_valid(frame_valid), .frame(frame), .busy(busy),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_erase(mem_erase), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_hi(mem_hi), .mem_wdata(mem_wdata), .lock_n(lock_n),
        .busy_start(busy_start), .load(load), .load_data(load_data)
    );

    isp_busy_timer #(.CLKS(BUSY_CLKS)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy)
    );
endmodule

// File: rtl/isp_cmd_checker.sv
// Protocol checker for isp_cmd_slave, attached by bind below.
// Assumes the mem_sel encoding of isp_pkg.
module isp_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_erase,
    input logic [1:0] mem_sel,
    input logic       busy,
    input logic [1:0] lock_n
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, mem_erase})); // R1
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R1
    AST_LOCK_RELEASE_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lock_n & ~$past(lock_n))) |-> mem_erase); // R7
    AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_sel != 2'd2) |-> lock_n[0]); // R8
    AST_NO_LOCKED_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_sel != 2'd2) |-> (lock_n != 2'b00)); // R9
    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_erase) |=> busy); // R10
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_erase) |-> !$past(busy)); // R10
endmodule

bind isp_cmd_slave isp_cmd_checker u_isp_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_erase(mem_erase), .mem_sel(mem_sel), .busy(busy), .lock_n(lock_n)
);

// File: tb/test_isp_cmd_slave.sv
// Scoreboard bench: expected writes are queued by the driver and
// compared by a monitor on every write strobe.
module test_isp_cmd_slave;
    localparam int BUSY = 1000;

    logic clk = 1'b0, rst_n = 1'b0, prog_rst_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo, mem_rd, mem_wr, mem_erase, mem_hi, busy;
    logic [1:0] mem_sel, lock_n;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    int n_cmp = 0, n_bad = 0, n_erase = 0;
    logic [15:0] pm [1024];
    logic [7:0]  dm [128];
    logic [7:0]  io [64];
    logic [20:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    isp_cmd_slave #(.BUSY_CLKS(BUSY)) i_isp_cmd_slave (
        .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_erase(mem_erase),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_hi(mem_hi),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .lock_n(lock_n)
    );

    // Memory model.
    always_comb begin
        case (mem_sel)
            2'd0:    mem_rdata = mem_hi ? pm[mem_addr][15:8] : pm[mem_addr][7:0];
            2'd1:    mem_rdata = dm[mem_addr[6:0]];
            2'd2:    mem_rdata = io[mem_addr[5:0]];
            default: mem_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (mem_wr) begin
            case (mem_sel)
                2'd0: if (mem_hi) pm[mem_addr][15:8] <= mem_wdata;
                      else        pm[mem_addr][7:0]  <= mem_wdata;
                2'd1: dm[mem_addr[6:0]] <= mem_wdata;
                2'd2: io[mem_addr[5:0]] <= mem_wdata;
                default: ;
            endcase
        end
        if (mem_erase) begin
            for (int i = 0; i < 1024; i++) pm[i] <= 16'hFFFF;
            for (int i = 0; i < 128; i++)  dm[i] <= 8'hFF;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare every write strobe against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && mem_erase) n_erase++;
        if (rst_n && mem_wr) begin
            if (exp_q.size() == 0) begin
                check("R10/R8 unexpected write", {11'd0, mem_sel, mem_addr, mem_hi, mem_wdata}, 32'hFFFFFFFF);
            end else begin
                logic [20:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {11'd0, mem_sel, mem_addr, mem_hi, mem_wdata}, {11'd0, e});
            end
        end
    end

    task automatic spi_bits(input logic [31:0] w, input int n, output logic [7:0] rd);
        rd = '0;
        for (int i = 0; i < n; i++) begin
            sdi = w[31-i];
            repeat (8) @(negedge clk);
            if (i >= 24) rd[31-i] = sdo;
            sck = 1'b1;
            repeat (16) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd(input logic [31:0] w);
        logic [7:0] dummy;
        spi_bits(w, 32, dummy);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_exp(input logic [31:0] w, input logic [1:0] sel, input logic [9:0] a,
                          input logic hi, input string tag);
        exp_q.push_back({sel, a, hi, w[7:0]});
        tag_q.push_back(tag);
        cmd(w);
        wait_idle();
    endtask

    task automatic rd_chk(input logic [31:0] w, input logic [7:0] exp, input string tag);
        logic [7:0] rd;
        spi_bits(w, 32, rd);
        check(tag, {24'd0, rd}, {24'd0, exp});
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) pm[i] = {i[7:0] ^ 8'h3C, i[7:0]};
        for (int i = 0; i < 128; i++)  dm[i] = i[7:0] ^ 8'hA5;
        for (int i = 0; i < 64; i++)   io[i] = 8'h00;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] junk;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 strobes", {29'd0, mem_rd, mem_wr, mem_erase}, 32'd0);
        check("R11 busy/sdo", {30'd0, busy, sdo}, 32'd0);
        check("R11 lock_n", {30'd0, lock_n}, 32'd3);

        prog_rst_n = 1'b0;
        repeat (10) @(negedge clk);
        // R3: not armed, write and read ignored
        cmd(32'hC0_00_05_5A);
        rd_chk(32'hA0_00_05_00, 8'h00, "R3 read before arming");
        cmd(32'hAC_53_00_00);
        rd_chk(32'hA0_00_05_00, 8'h05 ^ 8'hA5, "R3 write before arming dropped");

        // R4 program memory bytes, R1 field positions, R2 readback
        wr_exp(32'h40_02_34_A5, 2'd0, 10'h234, 1'b0, "R4 R1 pmem low write");
        wr_exp(32'h48_02_34_3C, 2'd0, 10'h234, 1'b1, "R4 pmem high write");
        rd_chk(32'h20_02_34_00, 8'hA5, "R4 R2 pmem low read");
        rd_chk(32'h28_02_34_00, 8'h3C, "R4 R2 pmem high read");
        rd_chk(32'h20_01_10_00, 8'h10, "R4 pmem untouched word");

        // R5 data memory and I/O address widths
        wr_exp(32'hC0_00_85_77, 2'd1, 10'h005, 1'b0, "R5 dmem write");
        rd_chk(32'hA0_00_05_00, 8'h77, "R5 dmem read");
        exp_q.push_back({2'd2, 10'h007, 1'b0, 8'h99});
        tag_q.push_back("R5 io write");
        cmd(32'hD0_00_C7_99);
        // R10 busy window timing
        check("R10 busy after write", {31'd0, busy}, 32'd1);
        repeat (BUSY - 60) @(negedge clk);
        check("R10 busy held", {31'd0, busy}, 32'd1);
        repeat (60) @(negedge clk);
        check("R10 busy released", {31'd0, busy}, 32'd0);
        rd_chk(32'hB0_00_07_00, 8'h99, "R5 io read");

        // R10 back-to-back write dropped
        exp_q.push_back({2'd1, 10'h00A, 1'b0, 8'h11});
        tag_q.push_back("R10 first write");
        cmd(32'hC0_00_0A_11);
        cmd(32'hC0_00_0A_22);
        wait_idle();
        rd_chk(32'hA0_00_0A_00, 8'h11, "R10 write during busy dropped");

        // R3 pin high clears arming and partial frame
        prog_rst_n = 1'b1; repeat (10) @(negedge clk);
        prog_rst_n = 1'b0; repeat (10) @(negedge clk);
        cmd(32'hC0_00_14_44);
        spi_bits(32'hFFF0_0000, 12, junk);
        prog_rst_n = 1'b1; repeat (10) @(negedge clk);
        prog_rst_n = 1'b0; repeat (10) @(negedge clk);
        cmd(32'hAC_53_00_00);
        rd_chk(32'hA0_00_14_00, 8'h14 ^ 8'hA5, "R3 disarmed by pin high");

        // R7 lock 1, R8 write protection
        cmd(32'hAC_E4_00_00);
        wait_idle();
        check("R7 lock 1 programmed", {30'd0, lock_n}, 32'd2);
        cmd(32'h40_00_10_5E);
        wait_idle();
        rd_chk(32'h20_00_10_00, 8'h10, "R8 pmem write locked");
        cmd(32'hC0_00_05_EE);
        wait_idle();
        rd_chk(32'hA0_00_05_00, 8'h77, "R8 dmem write locked");
        wr_exp(32'hD0_00_03_66, 2'd2, 10'h003, 1'b0, "R8 io write allowed");
        rd_chk(32'hB0_00_03_00, 8'h66, "R8 io readback");

        // R7 lock 2, R9 verify protection
        cmd(32'hAC_E2_00_00);
        wait_idle();
        check("R7 both locks", {30'd0, lock_n}, 32'd0);
        cmd(32'hAC_E6_00_00);
        wait_idle();
        check("R7 lock sticky", {30'd0, lock_n}, 32'd0);
        rd_chk(32'h20_02_34_00, 8'h00, "R9 pmem verify blocked");
        rd_chk(32'hA0_00_0A_00, 8'h00, "R9 dmem verify blocked");
        rd_chk(32'hB0_00_07_00, 8'h99, "R9 io read allowed");

        // R6 erase
        cmd(32'hAC_80_00_00);
        wait_idle();
        check("R6 locks released", {30'd0, lock_n}, 32'd3);
        check("R6 one erase strobe", n_erase, 1);
        rd_chk(32'h28_02_34_00, 8'hFF, "R6 pmem erased");
        rd_chk(32'hA0_00_0A_00, 8'hFF, "R6 dmem erased");

        // R1 unknown opcode ignored, scoreboard drained
        cmd(32'h55_12_34_56);
        wait_idle();
        check("R1 scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule